// File: doc/BRIEF.md
# Cache ECC Error Injection Controller

This block gives privileged software a way to turn on ECC checking in an instruction cache and to plant one deliberate ECC error in either the tag array or the data array. Software reaches it through a plain register port: one 64-bit control/status register and one 64-bit register that holds the physical address to corrupt. The cache arrays, the ECC codec and the recovery path stay outside. The block talks to them through two request/acknowledge handshakes: one for a residency lookup and one for the injection itself.

An injection starts when software writes a one to a trigger bit that never reads back as set. A small state machine then checks the request. It tests the enable bit and the target code first, then asks the cache whether the address is resident, then drives the injection to the array that was chosen. It posts the outcome in read-only status and reason fields. A finished result stays visible until software reads the control register. That read returns the result and sends the controller back to idle.

Top module: `ecc_inject_ctl`

## Requirements
- R1: After reset, both registers read as zero, `ecc_en` is low, and neither `lkp_req` nor `inj_req` is asserted.
- R2: At offset 0x0, bit 0 (check enable) and bits 3:2 (target) are written and read back. Bit 1 (the trigger) and bits 63:10 always read as zero.
- R3: The register at offset 0x8 keeps the low PA_W bits of a write, and the bits above them read as zero. Any other offset reads as zero, and a write to it changes neither register.
- R4: A write to offset 0x0 with bit 1 set, made while the status is idle (0), puts the status field (bits 6:4) at working (1) in the cycle after the write edge.
- R5: If check enable is 0 when the trigger is accepted, the status reads error (7) one cycle later, the reason field (bits 9:7) reads 0, and no lookup is issued.
- R6: If the target is a reserved code (1 or 3) and checking is enabled, the status reads error (7) one cycle later, the reason reads 1, and no lookup is issued.
- R7: For a valid request (target 0 = tag array, 2 = data array), `lkp_req` rises carrying the address register value on `req_addr`. It stays high until `lkp_ack`. If `lkp_hit` is low at the acknowledge, the status becomes error with reason 2.
- R8: On a hit, `inj_req` is raised with `inj_to_data` equal to 1 for the data array and 0 for the tag array. It stays high until `inj_ack`, and the status then becomes injected (2).
- R9: A read (`reg_rd_en`) of offset 0x0 while the status is injected or error returns that status. The status reads idle from the next cycle on. The reason field reads zero whenever the status is not error.
- R10: A trigger write that arrives while an injection is running, or while a result is pending, is ignored. Writes to the status and reason bits have no effect.
- R11: `ecc_en` always equals the stored check-enable bit.
- R12: `lkp_req` and `inj_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (clears a finished result) |
| reg_ofs | input | OFS_W | Byte offset of the register accessed |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_ofs`, combinational |
| ecc_en | output | 1 | ECC check enable to the cache |
| lkp_req | output | 1 | Residency lookup request |
| req_addr | output | PA_W | Physical address for lookup and injection |
| lkp_ack | input | 1 | Lookup acknowledge |
| lkp_hit | input | 1 | Lookup result, valid with `lkp_ack` |
| inj_req | output | 1 | Injection request |
| inj_to_data | output | 1 | 1 = data array, 0 = tag array |
| inj_ack | input | 1 | Injection acknowledge |

## Verification
The bench walks every combination of enable, the four target codes and lookup hit or miss, with acknowledge latencies of zero to two cycles.

- **Check order.** A design that checked residency before the enable and target tests would issue a stray lookup on a bad request, or would report reason 2 where 0 or 1 is due.
- **Stray trigger.** A second trigger sent while the lookup is pending must leave exactly one lookup and one injection. A design that restarts would show two.
- **Clear on read.** A design that cleared on any access, or never cleared, would show the wrong status on the read that follows.
- **Read-only bits.** Writes of ones to the read-only and reserved bits catch a field that can be written by mistake.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

  localparam int REG_W = 64;

  // control register bit positions (decoded by software)
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_GO_BIT  = 1;
  localparam int CTL_TGT_LSB = 2;
  localparam int CTL_STS_LSB = 4;
  localparam int CTL_WHY_LSB = 7;

  localparam logic [2:0] STS_IDLE = 3'd0;
  localparam logic [2:0] STS_BUSY = 3'd1;
  localparam logic [2:0] STS_DONE = 3'd2;
  localparam logic [2:0] STS_FAIL = 3'd7;

  localparam logic [2:0] WHY_NOEN = 3'd0;
  localparam logic [2:0] WHY_TGT  = 3'd1;
  localparam logic [2:0] WHY_MISS = 3'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_LOOKUP,
    ST_INJECT,
    ST_DONE_OK,
    ST_DONE_ERR
  } inj_state_e;

endpackage

// File: rtl/ecc_inj_csr.sv
module ecc_inj_csr
  import ecc_inj_pkg::*;
#(
  parameter int PA_W  = 48,
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [2:0]       status_i,
  input  logic [2:0]       why_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             en_o,
  output logic [1:0]       tgt_o,
  output logic [PA_W-1:0]  addr_o,
  output logic             start_o,
  output logic             clear_o
);

  localparam logic [OFS_W-1:0] CTL_OFS = '0;
  localparam logic [OFS_W-1:0] ADR_OFS = OFS_W'(8);

  logic             sel_ctl, sel_adr;
  logic             ctl_we, adr_we;
  logic             en_q;
  logic [1:0]       tgt_q;
  logic [PA_W-1:0]  addr_q;
  logic             unused_wbits;

  assign sel_ctl = (ofs_i == CTL_OFS);
  assign sel_adr = (ofs_i == ADR_OFS);
  assign ctl_we  = wr_en_i && sel_ctl;
  assign adr_we  = wr_en_i && sel_adr;

  assign start_o = ctl_we && wdata_i[CTL_GO_BIT];
  assign clear_o = rd_en_i && sel_ctl;

  assign unused_wbits = ^{wdata_i[REG_W-1:CTL_STS_LSB]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      tgt_q <= 2'd0;
    end else if (ctl_we) begin
      en_q  <= wdata_i[CTL_EN_BIT];
      tgt_q <= wdata_i[CTL_TGT_LSB +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (adr_we) begin
      addr_q <= wdata_i[PA_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctl) begin
      rdata_o[CTL_EN_BIT]         = en_q;
      rdata_o[CTL_TGT_LSB +: 2]   = tgt_q;
      rdata_o[CTL_STS_LSB +: 3]   = status_i;
      rdata_o[CTL_WHY_LSB +: 3]   = (status_i == STS_FAIL) ? why_i : 3'd0;
    end else if (sel_adr) begin
      rdata_o[PA_W-1:0] = addr_q;
    end
  end

  assign en_o   = en_q;
  assign tgt_o  = tgt_q;
  assign addr_o = addr_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adr_we |=> $stable(addr_q)) else $error("addr reg changed without write"); // R3

endmodule

// File: rtl/ecc_inj_fsm.sv
module ecc_inj_fsm
  import ecc_inj_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            clear_i,
  input  logic            en_i,
  input  logic [1:0]      tgt_i,
  input  logic [PA_W-1:0] addr_i,
  input  logic            lkp_ack_i,
  input  logic            lkp_hit_i,
  input  logic            inj_ack_i,
  output logic            lkp_req_o,
  output logic            inj_req_o,
  output logic            inj_data_o,
  output logic [PA_W-1:0] req_addr_o,
  output logic [2:0]      status_o,
  output logic [2:0]      why_o
);

  inj_state_e      st_q, st_d;
  logic [2:0]      why_q, why_d;
  logic            why_we;
  logic            cap_we;
  logic            sel_q;
  logic [PA_W-1:0] addr_q;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    why_d  = why_q;
    why_we = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_CHECK;
      ST_CHECK: begin
        if (!en_i) begin
          st_d = ST_DONE_ERR; why_d = WHY_NOEN; why_we = 1'b1;
        end else if (tgt_i[0]) begin
          st_d = ST_DONE_ERR; why_d = WHY_TGT;  why_we = 1'b1;
        end else begin
          st_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (lkp_ack_i) begin
          if (lkp_hit_i) begin
            st_d = ST_INJECT;
          end else begin
            st_d = ST_DONE_ERR; why_d = WHY_MISS; why_we = 1'b1;
          end
        end
      end
      ST_INJECT:   if (inj_ack_i) st_d = ST_DONE_OK;
      ST_DONE_OK,
      ST_DONE_ERR: if (clear_i) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  assign cap_we = (st_q == ST_CHECK);

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      why_q <= WHY_NOEN;
    else if (why_we) why_q <= why_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      addr_q <= '0;
    end else if (cap_we) begin
      sel_q  <= tgt_i[1];
      addr_q <= addr_i;
    end
  end

  // outputs
  always_comb begin
    unique case (st_q)
      ST_IDLE:     status_o = STS_IDLE;
      ST_DONE_OK:  status_o = STS_DONE;
      ST_DONE_ERR: status_o = STS_FAIL;
      default:     status_o = STS_BUSY;
    endcase
  end

  assign lkp_req_o  = (st_q == ST_LOOKUP);
  assign inj_req_o  = (st_q == ST_INJECT);
  assign inj_data_o = sel_q;
  assign req_addr_o = addr_q;
  assign why_o      = why_q;

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(lkp_req_o && inj_req_o)) else $error("both requests high"); // R12
  AST_LKP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_req_o && !lkp_ack_i) |=> lkp_req_o) else $error("lookup dropped"); // R7
  AST_INJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_req_o && !inj_ack_i) |=> inj_req_o) else $error("inject dropped"); // R8
  AST_LKP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lkp_req_o) |-> $past(en_i)) else $error("lookup while disabled"); // R5
  AST_LKP_NEEDS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lkp_req_o) |-> !$past(tgt_i[0])) else $error("lookup on reserved target"); // R6
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && (status_o == STS_DONE || status_o == STS_FAIL)) |=> (status_o == STS_IDLE))
    else $error("result not cleared"); // R9
  AST_BUSY_IGNORES_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_req_o && !lkp_ack_i && start_i) |=> lkp_req_o) else $error("restart while busy"); // R10

endmodule

// File: rtl/ecc_inject_ctl.sv
module ecc_inject_ctl
  import ecc_inj_pkg::*;
#(
  parameter int PA_W  = 48,
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_rd_en,
  input  logic [OFS_W-1:0] reg_ofs,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata,
  output logic             ecc_en,
  output logic             lkp_req,
  output logic [PA_W-1:0]  req_addr,
  input  logic             lkp_ack,
  input  logic             lkp_hit,
  output logic             inj_req,
  output logic             inj_to_data,
  input  logic             inj_ack
);

  logic [1:0]      rst_pipe_q;
  logic            rst_n_int;
  logic            en_w, start_w, clear_w;
  logic [1:0]      tgt_w;
  logic [PA_W-1:0] addr_w;
  logic [2:0]      status_w, why_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  ecc_inj_csr #(.PA_W(PA_W), .OFS_W(OFS_W)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en_i  (reg_wr_en),
    .rd_en_i  (reg_rd_en),
    .ofs_i    (reg_ofs),
    .wdata_i  (reg_wdata),
    .status_i (status_w),
    .why_i    (why_w),
    .rdata_o  (reg_rdata),
    .en_o     (en_w),
    .tgt_o    (tgt_w),
    .addr_o   (addr_w),
    .start_o  (start_w),
    .clear_o  (clear_w)
  );

  ecc_inj_fsm #(.PA_W(PA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start_i    (start_w),
    .clear_i    (clear_w),
    .en_i       (en_w),
    .tgt_i      (tgt_w),
    .addr_i     (addr_w),
    .lkp_ack_i  (lkp_ack),
    .lkp_hit_i  (lkp_hit),
    .inj_ack_i  (inj_ack),
    .lkp_req_o  (lkp_req),
    .inj_req_o  (inj_req),
    .inj_data_o (inj_to_data),
    .req_addr_o (req_addr),
    .status_o   (status_w),
    .why_o      (why_w)
  );

  assign ecc_en = en_w;

  AST_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (reg_wr_en && reg_ofs == '0) |=> (ecc_en == $past(reg_wdata[CTL_EN_BIT])))
    else $error("ecc_en does not follow write"); // R11

endmodule

// File: tb/ecc_inject_ctl_tb.sv
module ecc_inject_ctl_tb;
  localparam int PA_W  = 48;
  localparam int OFS_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [OFS_W-1:0] reg_ofs = '0;
  logic [63:0]      reg_wdata = '0;
  logic [63:0]      reg_rdata;
  logic             ecc_en, lkp_req, inj_req, inj_to_data;
  logic [PA_W-1:0]  req_addr;
  logic             lkp_ack = 1'b0, lkp_hit = 1'b0, inj_ack = 1'b0;

  int total = 0, bad = 0;
  int n_lkp = 0, n_inj = 0, n_both = 0, n_addr_bad = 0;
  int ack_dly = 0, lk_cnt = 0, ij_cnt = 0;
  logic            hit_cfg = 1'b0;
  logic            sel_seen = 1'b0;
  logic [PA_W-1:0] exp_addr = '0;

  always #4 clk = ~clk;

  ecc_inject_ctl #(.PA_W(PA_W), .OFS_W(OFS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_ofs(reg_ofs), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ecc_en(ecc_en), .lkp_req(lkp_req), .req_addr(req_addr),
    .lkp_ack(lkp_ack), .lkp_hit(lkp_hit), .inj_req(inj_req),
    .inj_to_data(inj_to_data), .inj_ack(inj_ack)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cache model: acknowledges after ack_dly waiting cycles
  always @(negedge clk) begin
    lkp_ack = 1'b0;
    inj_ack = 1'b0;
    if (lkp_req && inj_req) n_both++;
    if (lkp_req) begin
      if (req_addr !== exp_addr) n_addr_bad++;
      if (lk_cnt >= ack_dly) begin
        lkp_ack = 1'b1; lkp_hit = hit_cfg; lk_cnt = 0; n_lkp++;
      end else lk_cnt++;
    end
    if (inj_req) begin
      sel_seen = inj_to_data;
      if (req_addr !== exp_addr) n_addr_bad++;
      if (ij_cnt >= ack_dly) begin
        inj_ack = 1'b1; ij_cnt = 0; n_inj++;
      end else ij_cnt++;
    end
  end

  task automatic wr(input logic [OFS_W-1:0] ofs, input logic [63:0] d);
    reg_ofs = ofs; reg_wdata = d; reg_wr_en = 1'b1;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic peek(input logic [OFS_W-1:0] ofs, output logic [63:0] d);
    reg_ofs = ofs; #1; d = reg_rdata;
  endtask

  task automatic rdclr(output logic [63:0] d);
    reg_ofs = '0; reg_rd_en = 1'b1; #1; d = reg_rdata;
    @(posedge clk); #1;
    reg_rd_en = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [63:0] amask;
    amask = (64'd1 << PA_W) - 64'd1;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step();

    // R1: reset state
    peek(4'h0, d); chk("R1 ctrl", d, 64'd0);
    peek(4'h8, d); chk("R1 addr", d, 64'd0);
    chk("R1 req", {62'd0, lkp_req, inj_req}, 64'd0);
    chk("R1 ecc_en", {63'd0, ecc_en}, 64'd0);

    // R2 / R10: writable bits only; trigger bit clear so nothing starts
    wr(4'h0, ~64'h2);
    peek(4'h0, d); chk("R2 R10 ctrl readback", d, 64'h00D);
    chk("R11 ecc_en set", {63'd0, ecc_en}, 64'd1);
    wr(4'h0, 64'd0);
    chk("R11 ecc_en clr", {63'd0, ecc_en}, 64'd0);

    // R3: address width mask and unmapped offsets
    wr(4'h8, '1);
    peek(4'h8, d); chk("R3 addr mask", d, amask);
    wr(4'h4, 64'h5);
    peek(4'h4, d); chk("R3 unmapped read", d, 64'd0);
    peek(4'h0, d); chk("R3 ctrl untouched", d, 64'd0);
    peek(4'h8, d); chk("R3 addr untouched", d, amask);

    // sweep: enable x target x hit, varying ack latency
    for (int idx = 0; idx < 16; idx++) begin
      logic       en, hit;
      logic [1:0] tgt;
      logic [2:0] exp_sts, exp_why;
      logic [63:0] ctl;
      logic [PA_W-1:0] a;
      en  = idx[3];
      tgt = idx[2:1];
      hit = idx[0];
      ack_dly = idx % 3;
      hit_cfg = hit;
      a = PA_W'(64'h1234_5678_9000) + PA_W'(idx * 64);
      wr(4'h8, 64'(a));
      exp_addr = a;
      n_lkp = 0; n_inj = 0;
      ctl = {54'd0, 6'd0, tgt, 1'b1, en};
      wr(4'h0, ctl);
      peek(4'h0, d);
      chk("R4 working after trigger", {61'd0, d[6:4]}, 64'd1);
      chk("R11 ecc_en", {63'd0, ecc_en}, {63'd0, en});
      if (!en || tgt[0]) begin
        step();
        peek(4'h0, d);
        exp_sts = 3'd7;
        exp_why = !en ? 3'd0 : 3'd1;
        chk(!en ? "R5 status" : "R6 status", {61'd0, d[6:4]}, 64'd7);
        chk(!en ? "R5 reason" : "R6 reason", {61'd0, d[9:7]}, {61'd0, exp_why});
      end else begin
        // R10: second trigger while working, status bits set too
        wr(4'h0, ctl | 64'h3F0);
        for (int t = 0; t < 30; t++) begin
          peek(4'h0, d);
          if (d[6:4] != 3'd1) break;
          step();
        end
        if (hit) begin
          exp_sts = 3'd2; exp_why = 3'd0;
          chk("R8 status injected", {61'd0, d[6:4]}, 64'd2);
          chk("R8 one inject", 64'(n_inj), 64'd1);
          chk("R8 array select", {63'd0, sel_seen}, {63'd0, tgt[1]});
          chk("R9 reason hidden", {61'd0, d[9:7]}, 64'd0);
        end else begin
          exp_sts = 3'd7; exp_why = 3'd2;
          chk("R7 miss status", {61'd0, d[6:4]}, 64'd7);
          chk("R7 miss reason", {61'd0, d[9:7]}, 64'd2);
          chk("R7 no inject", 64'(n_inj), 64'd0);
        end
        chk("R10 one lookup", 64'(n_lkp), 64'd1);
      end
      if (!en || tgt[0]) begin
        chk("R5 R6 no lookup", 64'(n_lkp), 64'd0);
      end
      rdclr(d);
      chk("R9 read returns result", d,
          {54'd0, exp_why, exp_sts, tgt, 1'b0, en});
      peek(4'h0, d);
      chk("R9 idle after read", {58'd0, d[9:4]}, 64'd0);
    end

    chk("R7 R8 address on request", 64'(n_addr_bad), 64'd0);
    chk("R12 never both requests", 64'(n_both), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule